// File: doc/BRIEF.md
# Oscillator Trim Calibration Controller

This block tunes an 8-bit trim code for a local oscillator. The goal is that one period of an external reference clock spans a fixed number of local clock cycles. After a start strobe, the block first checks whether a stored trim value is already present. If one is present, it loads that value, raises an error flag and does not measure anything. If the stored value is erased, the block runs a loop. Each pass waits for the oscillator to settle, times one reference period against a free-running counter, compares the count with a target and moves the trim code toward it.

A higher trim code slows the oscillator, so a higher code gives fewer local cycles per reference period. The step taken each pass is the size of the error. From the sixteenth measurement onward the step is one. The loop stops in four cases: the count matches the target, the code is pinned at a limit in the direction it would need to move, or the thirty-second measurement is reached. When the loop stops, the block pulses done and a store request together, and the final code is shown beside them. Writing the code into nonvolatile memory is left to the surrounding logic.

Top module: `osc_trim_cal`

## Requirements
- R1: After reset, trimCode is 0x80, and done, storeReq and err are low.
- R2: A start while storedErased is low behaves as follows. storedTrim is copied to trimCode, err goes high, and done never pulses. A start while storedErased is high clears err.
- R3: The measured count is the number of local clock cycles between two successive synchronised rising edges of refIn. Only its low byte is compared, against 0x5B, which stands for a target of 0x15B. If the low byte equals 0x5B, the current code is accepted unchanged.
- R4: If the low byte is greater than 0x5B, the difference (low byte − 0x5B) is added to the trim code, saturating at 0xFF.
- R5: If the low byte is less than 0x5B, the difference (0x5B − low byte) is subtracted from the trim code, saturating at 0x00.
- R6: A fast result with the code at 0xFF, or a slow result with the code at 0x00, accepts that code.
- R7: Measurements are numbered from 1 after each start. From measurement 16 onward, every applied step has size one.
- R8: Measurement 32 is always accepted with no further adjustment.
- R9: Before each measurement, one reference rising edge is discarded. The period is then timed between the next two edges, so each timed period runs entirely at the current code.
- R10: On acceptance, done and storeReq are high for exactly one cycle and finalCode equals trimCode. The trim code does not change afterwards, until the next start or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, the oscillator under trim |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle strobe that begins calibration |
| refIn | input | 1 | External reference clock, asynchronous |
| storedTrim | input | 8 | Trim value read from nonvolatile storage |
| storedErased | input | 1 | High when the stored trim location is erased |
| trimCode | output | 8 | Live trim code driven to the oscillator |
| done | output | 1 | One-cycle pulse when a code is accepted |
| storeReq | output | 1 | One-cycle request to store finalCode |
| finalCode | output | 8 | Accepted trim code, valid with done |
| err | output | 1 | Stored value was present, so calibration was skipped |

## Verification
The bench models the oscillator as a reference period whose length depends on the trim code, and it runs several period laws against a model of the algorithm. Three laws converge to an exact match: one from the slow side, one from the fast side, and one whose first measurement already matches. Together they separate the add path, the subtract path and immediate acceptance, and they expose any measurement taken across a code change. Constant periods far above and below the target drive the code into saturation and then acceptance at 0xFF and at 0x00. A law whose count can never equal the target makes the code oscillate, which exposes the unit-step threshold and the iteration cap. A final run with a stored value present checks the skip path.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIter;
    logic incIter;
    logic clrFlag;
    logic markStart;
    logic loadStored;
    logic applyStep;
  } trimCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic capFlag;
    logic isEqual;
    logic isFast;
    logic atMax;
    logic atMin;
    logic iterCap;
  } trimStat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_FIRST,
    ST_SECOND,
    ST_DECIDE,
    ST_DONE
  } calState_t;

endpackage

// File: rtl/osc_trim_dp.sv
module osc_trim_dp
  import osc_trim_pkg::*;
#(
  parameter int TrimW = 8,
  parameter int CntW = 16,
  parameter int IterW = 6,
  parameter logic [TrimW-1:0] TargetLow = 8'h5B,
  parameter int FixStepAt = 16,
  parameter int IterCap = 32,
  parameter logic [TrimW-1:0] InitTrim = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refIn,
  input  logic [TrimW-1:0] storedTrim,
  input  trimCtl_t         ctl,
  output trimStat_t        stat,
  output logic [TrimW-1:0] trimCode,
  output logic [IterW-1:0] iterCnt
);
  localparam logic [TrimW-1:0] TrimMax = '1;
  localparam logic [TrimW-1:0] UnitStep = TrimW'(1);
  localparam logic [IterW-1:0] FixAtW = IterW'(FixStepAt);
  localparam logic [IterW-1:0] CapW = IterW'(IterCap);

  logic [2:0] syncQ;       // two synchroniser stages plus previous value
  logic edgeSeen;
  logic [CntW-1:0] freeCnt;
  logic [TrimW-1:0] capVal, startVal, measLow, delta, step, nextTrim;
  logic [TrimW:0] sumW, difW;
  logic capFlag;

  always_ff @(posedge clk) begin
    if (!rst_n) syncQ <= '0;
    else syncQ <= {syncQ[1:0], refIn};
  end

  assign edgeSeen = syncQ[1] & ~syncQ[2];

  // only the low byte of the wrapping difference is ever compared
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freeCnt <= '0;
      capVal <= '0;
      capFlag <= 1'b0;
      startVal <= '0;
    end else begin
      freeCnt <= freeCnt + 1'b1;
      if (edgeSeen) begin
        capVal <= freeCnt[TrimW-1:0];
        capFlag <= 1'b1;
      end else if (ctl.clrFlag) begin
        capFlag <= 1'b0;
      end
      if (ctl.markStart) startVal <= capVal;
    end
  end

  assign measLow = capVal - startVal;
  assign stat.isEqual = (measLow == TargetLow);
  assign stat.isFast = (measLow > TargetLow);
  assign delta = stat.isFast ? (measLow - TargetLow) : (TargetLow - measLow);
  assign step = (iterCnt >= FixAtW) ? UnitStep : delta;
  assign sumW = {1'b0, trimCode} + {1'b0, step};
  assign difW = {1'b0, trimCode} - {1'b0, step};
  assign nextTrim = stat.isFast ? (sumW[TrimW] ? TrimMax : sumW[TrimW-1:0])
                                : (difW[TrimW] ? '0 : difW[TrimW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iterCnt <= '0;
      trimCode <= InitTrim;
    end else begin
      if (ctl.clrIter) iterCnt <= '0;
      else if (ctl.incIter) iterCnt <= iterCnt + 1'b1;
      if (ctl.loadStored) trimCode <= storedTrim;
      else if (ctl.applyStep) trimCode <= nextTrim;
    end
  end

  assign stat.capFlag = capFlag;
  assign stat.atMax = (trimCode == TrimMax);
  assign stat.atMin = (trimCode == '0);
  assign stat.iterCap = (iterCnt >= CapW);

endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
  import osc_trim_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      storedErased,
  input  trimStat_t stat,
  output trimCtl_t  ctl,
  output logic      done,
  output logic      err
);
  calState_t state, nxt;
  logic accept;

  assign accept = stat.isEqual | (stat.isFast & stat.atMax) |
                  (~stat.isFast & stat.atMin) | stat.iterCap;

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      ST_IDLE: if (start) begin
        if (storedErased) begin
          ctl.clrIter = 1'b1;
          ctl.clrFlag = 1'b1;
          nxt = ST_SETTLE;
        end else begin
          ctl.loadStored = 1'b1;
        end
      end
      ST_SETTLE: if (stat.capFlag) begin   // discard one edge
        ctl.clrFlag = 1'b1;
        ctl.incIter = 1'b1;
        nxt = ST_FIRST;
      end
      ST_FIRST: if (stat.capFlag) begin
        ctl.markStart = 1'b1;
        ctl.clrFlag = 1'b1;
        nxt = ST_SECOND;
      end
      ST_SECOND: if (stat.capFlag) begin
        ctl.clrFlag = 1'b1;
        nxt = ST_DECIDE;
      end
      ST_DECIDE: if (accept) begin
        nxt = ST_DONE;
      end else begin
        ctl.applyStep = 1'b1;
        nxt = ST_SETTLE;
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      err <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start) err <= ~storedErased;
    end
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal
  import osc_trim_pkg::*;
#(
  parameter int TrimW = 8,
  parameter int CntW = 16,
  parameter int IterW = 6,
  parameter int FixStepAt = 16,
  parameter int IterCap = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             refIn,
  input  logic [TrimW-1:0] storedTrim,
  input  logic             storedErased,
  output logic [TrimW-1:0] trimCode,
  output logic             done,
  output logic             storeReq,
  output logic [TrimW-1:0] finalCode,
  output logic             err
);
  trimCtl_t ctl;
  trimStat_t stat;
  logic [IterW-1:0] iterCnt;

  osc_trim_dp #(
    .TrimW(TrimW), .CntW(CntW), .IterW(IterW),
    .TargetLow(TrimW'(8'h5B)), .FixStepAt(FixStepAt), .IterCap(IterCap),
    .InitTrim(TrimW'(8'h80))
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .refIn(refIn), .storedTrim(storedTrim),
    .ctl(ctl), .stat(stat), .trimCode(trimCode), .iterCnt(iterCnt)
  );

  osc_trim_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .storedErased(storedErased),
    .stat(stat), .ctl(ctl), .done(done), .err(err)
  );

  assign storeReq = done;
  assign finalCode = trimCode;

endmodule

// File: rtl/osc_trim_cal_chk.sv
module osc_trim_cal_chk #(
  parameter int TrimW = 8,
  parameter int IterW = 6,
  parameter int FixStepAt = 16,
  parameter int IterCap = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             err,
  input logic [TrimW-1:0] trimCode,
  input logic [IterW-1:0] iterCnt,
  input logic             stepApplied
);
  localparam logic [IterW-1:0] FixW = IterW'(FixStepAt);
  localparam logic [IterW-1:0] CapW = IterW'(IterCap);
  localparam logic [TrimW-1:0] One = TrimW'(1);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R10
  AST_DONE_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $stable(trimCode)) else $error("code moved at acceptance"); // R10
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done) else $error("done while skipped"); // R2
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stepApplied) && ($past(iterCnt) >= FixW)) |->
      ((trimCode == $past(trimCode) + One) || (trimCode == $past(trimCode) - One)))
    else $error("step not unit after threshold"); // R7
  AST_ITER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    stepApplied |-> (iterCnt < CapW)) else $error("step beyond cap"); // R8
  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stepApplied) |-> (trimCode != $past(trimCode)))
    else $error("applied step left code unchanged"); // R4

endmodule

bind osc_trim_cal osc_trim_cal_chk #(
  .TrimW(TrimW), .IterW(IterW), .FixStepAt(FixStepAt), .IterCap(IterCap)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .trimCode(trimCode),
  .iterCnt(iterCnt), .stepApplied(ctl.applyStep)
);

// File: tb/test_osc_trim_cal.sv
module test_osc_trim_cal;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic refIn = 1'b0;
  logic [7:0] storedTrim = 8'hFF;
  logic storedErased = 1'b1;
  logic [7:0] trimCode, finalCode;
  logic done, storeReq, err;

  int nVec = 0, nBad = 0;
  int scen = 5;
  int expQ[$];
  int idx = 0;
  int doneCount = 0;
  bit running = 1'b0;
  bit erasedRun = 1'b1;
  string tag = "";

  always #2.5 clk = ~clk;

  osc_trim_cal i_osc_trim_cal (
    .clk(clk), .rst_n(rst_n), .start(start), .refIn(refIn),
    .storedTrim(storedTrim), .storedErased(storedErased),
    .trimCode(trimCode), .done(done), .storeReq(storeReq),
    .finalCode(finalCode), .err(err)
  );

  // reference period in local cycles as a function of trim code
  function automatic int periodOf(int s, int t);
    case (s)
      0: return 400 - t / 2;
      1: return 480 - t;
      2: return 694 - 2 * t;
      3: return 500;
      4: return 300;
      default: return 347;
    endcase
  endfunction

  // expected sequence of trim codes for a run
  function automatic void buildModel(int s);
    int t = 128;
    int m, st;
    expQ.delete();
    expQ.push_back(t);
    for (int cnt = 1; cnt <= 40; cnt++) begin
      m = periodOf(s, t) % 256;
      if (m == 91) break;
      if (m > 91) begin
        if (t == 255 || cnt >= 32) break;
        st = (cnt >= 16) ? 1 : m - 91;
        t = (t + st > 255) ? 255 : t + st;
      end else begin
        if (t == 0 || cnt >= 32) break;
        st = (cnt >= 16) ? 1 : 91 - m;
        t = (t - st < 0) ? 0 : t - st;
      end
      expQ.push_back(t);
    end
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference generator: period sampled at each rising edge
  initial begin
    int p;
    repeat (2) @(negedge clk);
    forever begin
      p = periodOf(scen, int'(trimCode));
      refIn = 1'b1;
      repeat (p / 2) @(negedge clk);
      refIn = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (running) begin
      if (trimCode == 8'(expQ[idx])) begin
        check(1'b1, tag, trimCode, expQ[idx]);
      end else if (idx + 1 < expQ.size() && trimCode == 8'(expQ[idx + 1])) begin
        idx++;
        check(1'b1, tag, trimCode, expQ[idx]);
      end else begin
        check(1'b0, {tag, " trim sequence"}, trimCode, expQ[idx]);
      end
      check(storeReq == done, "R10 storeReq with done", storeReq, done);
      if (done) begin
        doneCount++;
        if (!erasedRun) check(1'b0, "R2 done after skip", 1, 0);
        else begin
          check(idx == expQ.size() - 1, {tag, " done at final step"}, idx, expQ.size() - 1);
          check(finalCode == trimCode, "R10 finalCode", finalCode, trimCode);
        end
      end
    end
  end

  task automatic runCal(input int s, input bit erased, input logic [7:0] stored, input string t);
    scen = s;
    erasedRun = erased;
    storedErased = erased;
    storedTrim = stored;
    tag = t;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(trimCode == 8'h80, "R1 reset trim", trimCode, 128);
    check(!done && !storeReq, "R1 reset done", done, 0);
    check(!err, "R1 reset err", err, 0);
    rst_n = 1'b1;
    if (erased) buildModel(s);
    else begin
      expQ.delete();
      expQ.push_back(128);
      expQ.push_back(int'(stored));
    end
    idx = 0;
    doneCount = 0;
    @(negedge clk);
    running = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (erased) begin
      for (int i = 0; i < 60000 && doneCount == 0; i++) @(negedge clk);
      repeat (40) @(negedge clk);
      check(doneCount == 1, {tag, " R10 single done"}, doneCount, 1);
      check(trimCode == 8'(expQ[expQ.size() - 1]), {tag, " final code"},
            trimCode, expQ[expQ.size() - 1]);
      check(!err, "R2 err clear on calibration", err, 0);
    end else begin
      repeat (2000) @(negedge clk);
      check(err, "R2 err raised", err, 1);
      check(trimCode == stored, "R2 stored code loaded", trimCode, stored);
      check(doneCount == 0, "R2 no done", doneCount, 0);
    end
    running = 1'b0;
  endtask

  initial begin
    runCal(5, 1'b1, 8'hFF, "R3 exact first measurement");
    runCal(0, 1'b1, 8'hFF, "R3 R5 R9 slow converge");
    runCal(1, 1'b1, 8'hFF, "R3 R4 R9 fast converge");
    runCal(3, 1'b1, 8'hFF, "R4 R6 saturate high");
    runCal(4, 1'b1, 8'hFF, "R5 R6 saturate low");
    runCal(2, 1'b1, 8'hFF, "R7 R8 unit step and cap");
    runCal(5, 1'b0, 8'h3C, "R2 stored present");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule